// File: doc/BRIEF.md
# Background Memory CRC Scrubber

This block watches over a memory array while the system keeps running. It reads the array one 32-bit word at a time through a simple read port. It folds every word into a single CRC-32 and compares the result with an expected value that was loaded earlier. After the last address it starts again at address 0, so the check repeats for as long as the system runs.

The block does not compare the two values directly. At the end of each sweep it stores the XOR of the computed CRC and the expected CRC in a signature register. A clean sweep leaves that register at zero, and any set bit raises a single error flag. The flag stays high until a later sweep produces a zero signature or a synchronous clear is applied. Loading a new expected value restarts the sweep from address 0.

The read port works as follows. The block presents `rd_addr`. The memory side returns the word for that address on `rd_data` and raises `rd_valid` in any cycle where the word is ready. The block accepts the word in that cycle and moves on to the next address.

Top module: `cfg_crc_scrubber`

## Requirements
- R1: After reset, `rd_addr` is 0, `signature` is 0, and `crc_err` and `sweep_done` are low.
- R2: `rd_addr` moves up by one on each clock edge where `rd_valid` is high and `exp_ld` is low. After the last address (2^ADDR_W-1) it returns to 0.
- R3: A single CRC covers all 2^ADDR_W words, taken in address order. The CRC is reflected, uses polynomial 0xEDB88320 and starts from all ones. Each word is shifted in least significant bit first, and the result is inverted at the end. This equals the standard CRC-32 of the words' bytes in little-endian order.
- R4: On the edge that accepts the last word, `signature` is loaded with (computed CRC XOR expected CRC). `sweep_done` is high for exactly the one following cycle, and the accumulator restarts at all ones.
- R5: `crc_err` is high exactly when `signature` is non-zero. A matching expected value keeps it low.
- R6: `signature` and `crc_err` keep their values between sweep ends. A raised error persists through later failing sweeps and drops only after a sweep that yields zero.
- R7: `clr` high zeroes `signature`, so `crc_err` is low in the next cycle. This also applies when a sweep ends in the same cycle.
- R8: `exp_ld` high stores `exp_din` as the expected CRC. `rd_addr` is 0 in the next cycle, and the partial CRC is discarded. A word offered in that same cycle is not accepted.
- R9: While `rd_valid` is low, `rd_addr` and the partial CRC are held. Gaps in `rd_valid` do not change the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| clr | input | 1 | Synchronous clear of signature and error |
| exp_ld | input | 1 | Load strobe for the expected CRC |
| exp_din | input | 32 | Expected CRC value |
| rd_addr | output | ADDR_W | Address of the word wanted next |
| rd_data | input | 32 | Word read from `rd_addr` |
| rd_valid | input | 1 | `rd_data` is valid this cycle |
| signature | output | 32 | Computed CRC XOR expected CRC from the last sweep |
| crc_err | output | 1 | Signature is non-zero |
| sweep_done | output | 1 | One-cycle pulse after each completed sweep |

## Verification
A wrong address counter shows up on `rd_addr` within one cycle. A corrupted accumulator or expected register stays hidden until the next sweep end, which can be up to 2^ADDR_W accepted words later. At that point it appears as a wrong `signature` alongside `sweep_done`. The bench therefore compares the full 32-bit signature and the error flag at every sweep end against a CRC computed byte-wise from its own copy of the memory. It also checks the flag between sweep ends, after a clear, and after a load made in the middle of a sweep.

// File: rtl/cfg_crc_scrubber.sv
module cfg_crc_scrubber #(
  parameter int          ADDR_W = 4,
  parameter logic [31:0] POLY   = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              exp_ld,
  input  logic [31:0]       exp_din,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  input  logic              rd_valid,
  output logic [31:0]       signature,
  output logic              crc_err,
  output logic              sweep_done
);
  localparam logic [ADDR_W-1:0] LAST = '1;

  function automatic logic [31:0] fold(input logic [31:0] c, input logic [31:0] d);
    logic [31:0] r;
    r = c ^ d;
    for (int i = 0; i < 32; i++)
      r = r[0] ? ((r >> 1) ^ POLY) : (r >> 1);
    return r;
  endfunction

  logic [31:0]       acc_q, exp_q, sig_q;
  logic [ADDR_W-1:0] addr_q;
  logic              done_q;
  logic [31:0]       acc_nxt;
  logic              take, wrap;

  assign take    = rd_valid & ~exp_ld;
  assign wrap    = take && (addr_q == LAST);
  assign acc_nxt = fold(acc_q, rd_data);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q  <= '1;
      exp_q  <= '0;
      sig_q  <= '0;
      addr_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= wrap;
      if (exp_ld) begin
        exp_q  <= exp_din;
        addr_q <= '0;
        acc_q  <= '1;
      end else if (take) begin
        addr_q <= addr_q + 1'b1;
        acc_q  <= wrap ? '1 : acc_nxt;
      end
      if (clr)
        sig_q <= '0;
      else if (wrap)
        sig_q <= ~acc_nxt ^ exp_q;
    end
  end

  assign rd_addr    = addr_q;
  assign signature  = sig_q;
  assign crc_err    = |sig_q;
  assign sweep_done = done_q;
endmodule

// File: rtl/cfg_crc_scrubber_chk.sv
module cfg_crc_scrubber_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              clr,
  input logic              exp_ld,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic [31:0]       signature,
  input logic              crc_err,
  input logic              sweep_done
);
  localparam logic [ADDR_W-1:0] TOP = '1;

  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !exp_ld |=> rd_addr == $past(rd_addr) + 1'b1);

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid && !exp_ld |=> $stable(rd_addr));

  assert_done_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !exp_ld && rd_addr == TOP |=> sweep_done);

  assert_done_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sweep_done |=> !sweep_done);

  assert_load_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    exp_ld |=> rd_addr == '0 && !sweep_done);

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> signature == '0 && !crc_err);

  assert_sig_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr && !(rd_valid && !exp_ld && rd_addr == TOP) |=> $stable(signature) && $stable(crc_err));
endmodule

bind cfg_crc_scrubber cfg_crc_scrubber_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .exp_ld(exp_ld), .rd_addr(rd_addr),
  .rd_valid(rd_valid), .signature(signature), .crc_err(crc_err), .sweep_done(sweep_done)
);

// File: tb/tb_cfg_crc_scrubber.sv
module tb_cfg_crc_scrubber;
  localparam int AW = 4;
  localparam int N  = 1 << AW;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, exp_ld = 1'b0;
  logic [31:0] exp_din = '0;
  logic [AW-1:0] rd_addr;
  logic [31:0] rd_data, signature;
  logic rd_valid, crc_err, sweep_done;
  logic vld_en = 1'b0, gap_mode = 1'b0, gap_tgl = 1'b0;
  logic [31:0] mem [N];
  logic [31:0] q [$];
  int compared = 0, mismatched = 0;
  bit  reported = 0;
  logic prev_done = 1'b0;

  always #10 clk = ~clk;

  assign rd_data  = mem[rd_addr];
  assign rd_valid = vld_en & (~gap_mode | gap_tgl);

  cfg_crc_scrubber #(.ADDR_W(AW)) dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .exp_ld(exp_ld), .exp_din(exp_din),
    .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .signature(signature), .crc_err(crc_err), .sweep_done(sweep_done)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    end
  endtask

  // R3 reference: byte-wise standard CRC-32, little-endian bytes of each word
  function automatic logic [31:0] ref_crc();
    logic [31:0] c = '1;
    for (int w = 0; w < N; w++)
      for (int b = 0; b < 4; b++) begin
        c ^= {24'h0, mem[w][8*b +: 8]};
        for (int k = 0; k < 8; k++)
          c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
      end
    return ~c;
  endfunction

  always @(negedge clk) begin
    gap_tgl <= ~gap_tgl;
    if (rst_n && sweep_done) begin
      check("R4 single-cycle done", {31'b0, prev_done}, 32'h0);
      if (q.size() == 0) begin
        check("R4 unexpected sweep_done", 32'h1, 32'h0);
      end else begin
        logic [31:0] e;
        e = q.pop_front();
        check("R3/R4 signature", signature, e);
        check("R5 crc_err vs signature", {31'b0, crc_err}, {31'b0, e != 0});
      end
    end
    prev_done <= sweep_done;
  end

  task automatic load(input logic [31:0] v);
    @(negedge clk); exp_ld = 1'b1; exp_din = v;
    @(negedge clk); exp_ld = 1'b0;
    check("R8 rd_addr after load", {28'h0, rd_addr}, 32'h0);
  endtask

  task automatic run_sweep(input logic [31:0] exp_sig);
    q.push_back(exp_sig);
    vld_en = 1'b1;
    do @(negedge clk); while (!sweep_done);
    vld_en = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check("watchdog expired", 32'h1, 32'h0);
    summary();
    $finish;
  end

  initial begin
    logic [31:0] good, bad, a0;
    for (int i = 0; i < N; i++) mem[i] = (i * 32'h9E3779B9) ^ 32'h0BAD_1234;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 rd_addr reset", {28'h0, rd_addr}, 32'h0);
    check("R1 signature reset", signature, 32'h0);
    check("R1 crc_err reset", {31'b0, crc_err}, 32'h0);
    check("R1 sweep_done reset", {31'b0, sweep_done}, 32'h0);

    good = ref_crc();
    load(good);
    run_sweep(32'h0);
    check("R5 clean pass no error", {31'b0, crc_err}, 32'h0);

    // R2/R9 partial advance then stall
    vld_en = 1'b1;
    repeat (3) @(negedge clk);
    vld_en = 1'b0;
    check("R2 advanced three words", {28'h0, rd_addr}, 32'd3);
    a0 = {28'h0, rd_addr};
    repeat (4) @(negedge clk);
    check("R9 address held while idle", {28'h0, rd_addr}, a0);
    run_sweep(32'h0);
    check("R9 stall keeps clean result", {31'b0, crc_err}, 32'h0);

    gap_mode = 1'b1;
    run_sweep(32'h0);
    gap_mode = 1'b0;
    check("R9 gapped valid clean result", {31'b0, crc_err}, 32'h0);

    // R5/R6 wrong expected value
    load(good ^ 32'h00F0_0001);
    run_sweep(32'h00F0_0001);
    repeat (5) @(negedge clk);
    check("R6 error persists between sweeps", {31'b0, crc_err}, 32'h1);
    check("R6 signature persists", signature, 32'h00F0_0001);
    run_sweep(32'h00F0_0001);
    check("R6 error after second failing sweep", {31'b0, crc_err}, 32'h1);
    load(good);
    run_sweep(32'h0);
    check("R6 error drops after clean sweep", {31'b0, crc_err}, 32'h0);

    // R3 corrupted memory word
    mem[7] ^= 32'h0000_0100;
    bad = ref_crc();
    run_sweep(bad ^ good);
    check("R3 corruption detected", {31'b0, crc_err}, 32'h1);
    mem[7] ^= 32'h0000_0100;

    // R7 clear
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    check("R7 clear drops error", {31'b0, crc_err}, 32'h0);
    check("R7 clear zeroes signature", signature, 32'h0);

    // R7 clear coinciding with sweep end
    mem[3] ^= 32'h1;
    q.push_back(32'h0);
    vld_en = 1'b1;
    @(negedge clk);
    while (rd_addr != AW'(N - 1)) @(negedge clk);
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0;
    vld_en = 1'b0;
    check("R7 clear wins at sweep end", {31'b0, crc_err}, 32'h0);
    mem[3] ^= 32'h1;

    // R8 load mid-sweep discards partial CRC
    vld_en = 1'b1;
    repeat (6) @(negedge clk);
    load(good);
    run_sweep(32'h0);
    check("R8 restart after mid-sweep load", {31'b0, crc_err}, 32'h0);

    repeat (4) @(negedge clk);
    check("R4 all expected sweeps seen", q.size(), 32'h0);
    summary();
    $finish;
  end
endmodule